// File: doc/BRIEF.md
# TDM time-slot routing sequencer

This block decides, slot by slot, where the data of a TDM frame goes. Each direction (transmit and receive) has its own route list. A route list is a sequence of runs, and each run names how many consecutive slots it covers and which of five internal serial channels those slots belong to. Code zero marks slots that belong to no channel. The framer supplies a frame-start strobe and a slot-boundary strobe for each direction. The sequencer expands the runs as the slots go by and presents a destination code with a one-cycle valid pulse for every slot.

Route lists are loaded through a one-word write port into a small two-bank RAM per direction. Writes always land in the shadow bank. Any accepted write arms a swap, and the swap takes place at the next frame start of that direction, so a frame already in progress never sees a half-written table. The bank that comes out of a swap as shadow holds the previous table, so software writes each new list in full. A marker bit in the entry ends the list. The index of the marked entry is kept per bank in a register, and the walker compares against that register and does not read the bit back.

The data switch uses the codes. Toward the line it forwards the selected channel's transmit word, or all ones for an unused slot. From the line it hands each received word to the selected channel with a one-hot write strobe, and it drops words that arrive in unused slots.

Top module: `tsr_top`

## Requirements
- R1: While and after reset, and before any frame start, `tx_dest`/`rx_dest` are 0, `tx_valid`/`rx_valid` are 0, `tx_line_data` is all ones and `ch_rx_we` is 0.
- R2: Config word layout: bits [5:0] = run length minus one (so lengths 1..64), bits [8:6] = destination code (0 = unused, 1..5 = channel 1..5), bit 9 = last-entry marker, bits [11:10] = reserved. `cfg_dir` 0 selects the transmit table and 1 selects the receive table. A frame strobe starts the list at entry 0 for slot 0, and each run covers exactly its length in slots before the next entry is used. The code and a one-cycle valid pulse appear two clock edges after the edge that samples the strobe.
- R3: Once the run of the marked last entry is exhausted, every further slot of that frame reports code 0.
- R4: A bank that has never received a marked entry reports code 0 for every slot.
- R5: Writes go to the shadow bank. The active list is unchanged for the rest of the current frame and takes the new content at the next frame start.
- R6: A write sampled on the same edge as a frame strobe belongs to the following table. The frame that starts on that edge uses the table that was active or pending before it.
- R7: When a frame strobe and a slot strobe are sampled together, the frame strobe wins and the list restarts at entry 0.
- R8: A write with a non-zero reserved field, or with a destination code above 5, is discarded. It changes no entry and does not arm a swap.
- R9: The transmit and receive tables and their sequencing are independent.
- R10: `tx_line_data` follows the transmit code one cycle later. It carries channel k's word for code k and all ones for code 0.
- R11: When `rx_line_vld` is high, the next cycle shows `ch_rx_data` holding the word and `ch_rx_we` one-hot on the channel of the current receive code. For code 0 no write strobe is raised.
- R12: A run of the maximum length 64 covers exactly 64 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Route entry write strobe |
| cfg_dir | input | 1 | Table select: 0 transmit, 1 receive |
| cfg_addr | input | 6 | Entry index |
| cfg_word | input | 12 | Entry word (layout in R2) |
| tx_frame | input | 1 | Transmit frame-start strobe |
| tx_slot | input | 1 | Transmit slot-boundary strobe |
| rx_frame | input | 1 | Receive frame-start strobe |
| rx_slot | input | 1 | Receive slot-boundary strobe |
| tx_dest | output | 3 | Current transmit destination code |
| tx_valid | output | 1 | Pulse: new transmit slot code |
| rx_dest | output | 3 | Current receive destination code |
| rx_valid | output | 1 | Pulse: new receive slot code |
| ch_tx_data | input | 40 | Transmit words of channels 1..5, channel k at bits [8k-1:8k-8] |
| tx_line_data | output | 8 | Word toward the line |
| rx_line_vld | input | 1 | Received word strobe |
| rx_line_data | input | 8 | Received word |
| ch_rx_data | output | 8 | Word handed to the channels |
| ch_rx_we | output | 5 | One-hot channel write strobe |

## Verification
Two pairs of functions can land on the same edge. A frame strobe can coincide with a slot strobe, and a table write can coincide with a frame strobe, which is the edge where the bank swap is decided. The bench drives both pairs in a single cycle. For the first pair it expects the code of entry 0 and never the code the slot advance would have produced. For the second it expects the frame that starts to keep the old list and the frame after it to show the written entry.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int NUM_CH  = 5;
  localparam int DEST_W  = 3;
  localparam int MAX_RUN = 64;
  localparam int CNT_W   = $clog2(MAX_RUN);
  localparam int RSV_W   = 2;

  typedef struct packed {
    logic [RSV_W-1:0]  rsvd;
    logic              last;
    logic [DEST_W-1:0] dest;
    logic [CNT_W-1:0]  cnt_m1;
  } route_ent_t;

  localparam int ENT_W = $bits(route_ent_t);
endpackage

// File: rtl/tsr_table.sv
module tsr_table
  import tsr_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  route_ent_t    wr_ent,
  input  logic          frame_go,
  input  logic [AW-1:0] rd_addr,
  output route_ent_t    rd_ent,
  output logic [AW-1:0] act_last,
  output logic          act_ok
);
  localparam int MEM_N = 2 * DEPTH;

  logic [ENT_W-1:0] mem [MEM_N];
  logic [ENT_W-1:0] rd_q;
  logic             act_q;
  logic             pend_q;
  logic [AW-1:0]    last_q [2];
  logic             ok_q [2];

  logic wr_ok;
  logic swap;
  logic act_nx;
  logic wr_bank;

  assign wr_ok   = wr_en && (wr_ent.rsvd == '0) && (wr_ent.dest <= DEST_W'(NUM_CH));
  assign swap    = frame_go && pend_q;
  assign act_nx  = act_q ^ swap;
  assign wr_bank = ~act_nx;

  // bank bookkeeping
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      pend_q    <= 1'b0;
      last_q[0] <= '0;
      last_q[1] <= '0;
      ok_q[0]   <= 1'b0;
      ok_q[1]   <= 1'b0;
    end else begin
      act_q <= act_nx;
      if (wr_ok)
        pend_q <= 1'b1;
      else if (swap)
        pend_q <= 1'b0;
      if (wr_ok && wr_ent.last) begin
        last_q[wr_bank] <= wr_addr;
        ok_q[wr_bank]   <= 1'b1;
      end
    end
  end

  // simple dual-port RAM, registered read
  always_ff @(posedge clk) begin
    if (wr_ok)
      mem[{wr_bank, wr_addr}] <= wr_ent;
    rd_q <= mem[{act_nx, rd_addr}];
  end

  assign rd_ent   = route_ent_t'(rd_q);
  assign act_last = last_q[act_q];
  assign act_ok   = ok_q[act_q];

  a_r5_swap_on_frame: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> $past(frame_go));

  a_r8_pend_needs_clean_write: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(wr_en && (wr_ent.rsvd == '0) && (wr_ent.dest <= DEST_W'(NUM_CH))));
endmodule

// File: rtl/tsr_walker.sv
module tsr_walker
  import tsr_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_go,
  input  logic              slot_go,
  input  logic [AW-1:0]     act_last,
  input  logic              act_ok,
  input  route_ent_t        rd_ent,
  output logic [AW-1:0]     rd_addr,
  output logic [DEST_W-1:0] dest_o,
  output logic              valid_o
);
  logic [AW-1:0]    idx_q, idx_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic             ended_q, end_n;
  logic             pend_q;
  logic             load_q, load_n;

  // edge 0: decide next entry and issue the RAM read
  always_comb begin
    load_n  = 1'b0;
    idx_n   = idx_q;
    rem_n   = rem_q;
    end_n   = ended_q;
    rd_addr = idx_q;
    if (frame_go) begin
      load_n  = 1'b1;
      idx_n   = '0;
      end_n   = 1'b0;
      rd_addr = '0;
    end else if (slot_go && !ended_q) begin
      if (rem_q != '0) begin
        rem_n = rem_q - 1'b1;
      end else if (idx_q == act_last) begin
        end_n = 1'b1;
      end else begin
        load_n  = 1'b1;
        idx_n   = idx_q + 1'b1;
        rd_addr = idx_q + 1'b1;
      end
    end
  end

  // edge 1: take the entry and publish the code
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      rem_q   <= '0;
      ended_q <= 1'b1;
      pend_q  <= 1'b0;
      load_q  <= 1'b0;
      dest_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      pend_q  <= frame_go || slot_go;
      load_q  <= load_n;
      idx_q   <= idx_n;
      valid_o <= pend_q;
      rem_q   <= rem_n;
      ended_q <= end_n;
      if (pend_q && load_q) begin
        if (act_ok) begin
          dest_o <= rd_ent.dest;
          rem_q  <= rd_ent.cnt_m1;
        end else begin
          dest_o  <= '0;
          ended_q <= 1'b1;
        end
      end else if (pend_q && ended_q) begin
        dest_o <= '0;
      end
    end
  end

  a_r2_valid_timing: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(frame_go || slot_go, 2));

  a_r3_ended_is_unused: assert property (@(posedge clk) disable iff (rst)
    (ended_q && !pend_q) |-> (dest_o == '0));

  a_r7_frame_restarts: assert property (@(posedge clk) disable iff (rst)
    frame_go |=> (idx_q == '0));
endmodule

// File: rtl/tsr_switch.sv
module tsr_switch
  import tsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DEST_W-1:0]        tx_dest,
  input  logic [NUM_CH*DATA_W-1:0] ch_tx_data,
  output logic [DATA_W-1:0]        tx_line_data,
  input  logic [DEST_W-1:0]        rx_dest,
  input  logic                     rx_line_vld,
  input  logic [DATA_W-1:0]        rx_line_data,
  output logic [DATA_W-1:0]        ch_rx_data,
  output logic [NUM_CH-1:0]        ch_rx_we
);
  logic [DATA_W-1:0] tx_sel;
  logic [NUM_CH-1:0] we_n;

  always_comb begin
    tx_sel = '1;
    for (int k = 0; k < NUM_CH; k++)
      if (tx_dest == DEST_W'(k + 1))
        tx_sel = ch_tx_data[k*DATA_W +: DATA_W];
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_we
    assign we_n[k] = rx_line_vld && (rx_dest == DEST_W'(k + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_line_data <= '1;
      ch_rx_data   <= '0;
      ch_rx_we     <= '0;
    end else begin
      tx_line_data <= tx_sel;
      ch_rx_we     <= we_n;
      if (rx_line_vld)
        ch_rx_data <= rx_line_data;
    end
  end

  a_r10_idle_ones: assert property (@(posedge clk) disable iff (rst)
    (tx_dest == '0) |=> (tx_line_data == '1));

  a_r11_single_channel: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_rx_we));

  a_r11_unused_dropped: assert property (@(posedge clk) disable iff (rst)
    (rx_line_vld && (rx_dest == '0)) |=> (ch_rx_we == '0));
endmodule

// File: rtl/tsr_top.sv
module tsr_top
  import tsr_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic                     cfg_dir,
  input  logic [AW-1:0]            cfg_addr,
  input  logic [ENT_W-1:0]         cfg_word,
  input  logic                     tx_frame,
  input  logic                     tx_slot,
  input  logic                     rx_frame,
  input  logic                     rx_slot,
  output logic [DEST_W-1:0]        tx_dest,
  output logic                     tx_valid,
  output logic [DEST_W-1:0]        rx_dest,
  output logic                     rx_valid,
  input  logic [NUM_CH*DATA_W-1:0] ch_tx_data,
  output logic [DATA_W-1:0]        tx_line_data,
  input  logic                     rx_line_vld,
  input  logic [DATA_W-1:0]        rx_line_data,
  output logic [DATA_W-1:0]        ch_rx_data,
  output logic [NUM_CH-1:0]        ch_rx_we
);
  logic [1:0]        fr_v;
  logic [1:0]        sl_v;
  logic [DEST_W-1:0] dest_v  [2];
  logic [1:0]        valid_v;

  assign fr_v = {rx_frame, tx_frame};
  assign sl_v = {rx_slot, tx_slot};

  // index 0 = transmit, 1 = receive
  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [AW-1:0] rd_addr;
    route_ent_t    rd_ent;
    logic [AW-1:0] act_last;
    logic          act_ok;

    tsr_table #(.DEPTH(DEPTH)) u_tbl (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (cfg_we && (cfg_dir == 1'(d))),
      .wr_addr  (cfg_addr),
      .wr_ent   (route_ent_t'(cfg_word)),
      .frame_go (fr_v[d]),
      .rd_addr  (rd_addr),
      .rd_ent   (rd_ent),
      .act_last (act_last),
      .act_ok   (act_ok)
    );

    tsr_walker #(.DEPTH(DEPTH)) u_walk (
      .clk      (clk),
      .rst      (rst),
      .frame_go (fr_v[d]),
      .slot_go  (sl_v[d]),
      .act_last (act_last),
      .act_ok   (act_ok),
      .rd_ent   (rd_ent),
      .rd_addr  (rd_addr),
      .dest_o   (dest_v[d]),
      .valid_o  (valid_v[d])
    );
  end

  assign tx_dest  = dest_v[0];
  assign tx_valid = valid_v[0];
  assign rx_dest  = dest_v[1];
  assign rx_valid = valid_v[1];

  tsr_switch #(.DATA_W(DATA_W)) u_sw (
    .clk          (clk),
    .rst          (rst),
    .tx_dest      (dest_v[0]),
    .ch_tx_data   (ch_tx_data),
    .tx_line_data (tx_line_data),
    .rx_dest      (dest_v[1]),
    .rx_line_vld  (rx_line_vld),
    .rx_line_data (rx_line_data),
    .ch_rx_data   (ch_rx_data),
    .ch_rx_we     (ch_rx_we)
  );
endmodule

// File: tb/sim_tsr_top.sv
module sim_tsr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_dir = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [11:0] cfg_word = '0;
  logic        tx_frame = 1'b0, tx_slot = 1'b0, rx_frame = 1'b0, rx_slot = 1'b0;
  logic [2:0]  tx_dest, rx_dest;
  logic        tx_valid, rx_valid;
  logic [39:0] ch_tx_data;
  logic [7:0]  tx_line_data;
  logic        rx_line_vld = 1'b0;
  logic [7:0]  rx_line_data = '0;
  logic [7:0]  ch_rx_data;
  logic [4:0]  ch_rx_we;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // channel k (code k) sends 8'hA0 + k
  assign ch_tx_data = {8'hA5, 8'hA4, 8'hA3, 8'hA2, 8'hA1};

  always #10 clk = ~clk;

  tsr_top u0 (.*);

  // ---- reference model built from the requirements ----
  int m_cnt  [2][2][64];
  int m_dst  [2][2][64];
  int m_last [2][2];
  int m_act  [2];
  bit m_pend [2];
  int w_idx [2], w_rem [2], w_dst [2];
  bit w_end [2];

  logic [2:0] q_exp [2][$];

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void m_load(int d);
    int a = m_act[d];
    w_rem[d] = m_cnt[d][a][w_idx[d]] - 1;
    w_dst[d] = m_dst[d][a][w_idx[d]];
  endfunction

  function automatic void m_frame(int d);
    if (m_pend[d]) begin m_act[d] ^= 1; m_pend[d] = 0; end
    if (m_last[d][m_act[d]] < 0) begin
      w_end[d] = 1; w_dst[d] = 0;
    end else begin
      w_end[d] = 0; w_idx[d] = 0; m_load(d);
    end
  endfunction

  function automatic void m_slot(int d);
    if (w_end[d]) w_dst[d] = 0;
    else if (w_rem[d] > 0) w_rem[d]--;
    else if (w_idx[d] == m_last[d][m_act[d]]) begin w_end[d] = 1; w_dst[d] = 0; end
    else begin w_idx[d]++; m_load(d); end
  endfunction

  function automatic void m_write(int d, int addr, int cnt, int dst, bit last, int rsv);
    int b;
    if (rsv != 0 || dst > 5) return;
    b = m_act[d] ^ 1;
    m_cnt[d][b][addr] = cnt;
    m_dst[d][b][addr] = dst;
    if (last) m_last[d][b] = addr;
    m_pend[d] = 1;
  endfunction

  // ---- driver ----
  task automatic set_cfg(int d, int addr, int cnt, int dst, bit last, int rsv);
    cfg_we   = 1'b1;
    cfg_dir  = 1'(d);
    cfg_addr = 6'(addr);
    cfg_word = {2'(rsv), last, 3'(dst), 6'(cnt - 1)};
  endtask

  task automatic wr(int d, int addr, int cnt, int dst, bit last, int rsv);
    @(negedge clk);
    set_cfg(d, addr, cnt, dst, last, rsv);
    m_write(d, addr, cnt, dst, last, rsv);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one slot event; optional write sampled on the same edge
  task automatic strobe(int d, bit fr, bit sl, bit with_wr = 0,
                        int addr = 0, int cnt = 1, int dst = 0, bit last = 0);
    logic [4:0] exp_we;
    @(negedge clk);
    if (d == 0) begin tx_frame = fr; tx_slot = sl; end
    else        begin rx_frame = fr; rx_slot = sl; end
    if (fr) m_frame(d); else m_slot(d);
    if (with_wr) begin
      set_cfg(d, addr, cnt, dst, last, 0);
      m_write(d, addr, cnt, dst, last, 0);
    end
    q_exp[d].push_back(3'(w_dst[d]));
    @(negedge clk);
    tx_frame = 0; tx_slot = 0; rx_frame = 0; rx_slot = 0; cfg_we = 1'b0;
    @(negedge clk);
    if (d == 1) begin
      rx_line_vld  = 1'b1;
      rx_line_data = 8'(8'h30 + w_idx[1] + w_rem[1]);
      exp_we = (w_dst[1] == 0) ? 5'd0 : 5'(1 << (w_dst[1] - 1));
      @(negedge clk);
      chk("R11 ch_rx_we", ch_rx_we, exp_we);
      if (exp_we != 0) chk("R11 ch_rx_data", ch_rx_data, 8'(8'h30 + w_idx[1] + w_rem[1]));
      rx_line_vld = 1'b0;
    end
  endtask

  task automatic run_frame(int d, int n);
    strobe(d, 1, 0);
    for (int i = 1; i < n; i++) strobe(d, 0, 1);
  endtask

  // ---- monitor ----
  bit   tx_line_pend = 0;
  int   tx_line_exp  = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_line_pend) begin
        chk("R10 tx_line_data", tx_line_data, tx_line_exp);
        tx_line_pend = 0;
      end
      if (tx_valid) begin
        if (q_exp[0].size() == 0) chk("R2 unexpected tx_valid", 1, 0);
        else begin
          logic [2:0] e;
          e = q_exp[0].pop_front();
          chk("R2 tx_dest", tx_dest, e);
          tx_line_pend = 1;
          tx_line_exp  = (e == 0) ? 8'hFF : 8'hA0 + e;
        end
      end
      if (rx_valid) begin
        if (q_exp[1].size() == 0) chk("R2 unexpected rx_valid", 1, 0);
        else begin
          logic [2:0] e;
          e = q_exp[1].pop_front();
          chk("R9 rx_dest", rx_dest, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      m_act[d] = 0; m_pend[d] = 0; w_end[d] = 1; w_dst[d] = 0; w_idx[d] = 0; w_rem[d] = 0;
      m_last[d][0] = -1; m_last[d][1] = -1;
    end
    repeat (4) @(negedge clk);
    chk("R1 tx_line_data in reset", tx_line_data, 8'hFF);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 tx_dest", tx_dest, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_line_data", tx_line_data, 8'hFF);
    chk("R1 ch_rx_we", ch_rx_we, 0);

    // R4: no table yet
    run_frame(0, 3);
    run_frame(1, 2);

    // R2, R3, R10: transmit list 2x unused, 3x ch1, 4x unused, 2x ch2 then end
    wr(0, 0, 2, 0, 0, 0);
    wr(0, 1, 3, 1, 0, 0);
    wr(0, 2, 4, 0, 0, 0);
    wr(0, 3, 2, 2, 1, 0);
    // R9, R11: receive list 3x ch5, 1x ch4
    wr(1, 0, 3, 5, 0, 0);
    wr(1, 1, 1, 4, 1, 0);
    run_frame(0, 13);
    run_frame(1, 6);

    // R5: write mid-frame, old list keeps running
    strobe(0, 1, 0);
    strobe(0, 0, 1);
    wr(0, 0, 1, 4, 1, 0);
    strobe(0, 0, 1);
    strobe(0, 0, 1);
    strobe(0, 0, 1);
    run_frame(0, 3);

    // R6: write on the same edge as a frame start
    strobe(0, 1, 0, 1, 0, 2, 3, 1);
    strobe(0, 0, 1);
    run_frame(0, 3);

    // R7: frame and slot strobes together
    strobe(0, 1, 0);
    strobe(0, 0, 1);
    strobe(0, 0, 1);
    strobe(0, 1, 1);
    strobe(0, 0, 1);

    // R8: rejected writes
    wr(0, 0, 1, 5, 1, 0);
    wr(0, 0, 1, 2, 1, 1);
    wr(0, 0, 1, 6, 1, 0);
    run_frame(0, 2);
    wr(0, 0, 3, 1, 1, 2);
    run_frame(0, 2);

    // R12: maximum run length on receive, then R9 check transmit unaffected
    wr(1, 0, 64, 1, 0, 0);
    wr(1, 1, 1, 2, 1, 0);
    run_frame(1, 66);
    run_frame(0, 2);

    repeat (4) @(negedge clk);
    chk("R2 tx queue drained", q_exp[0].size(), 0);
    chk("R2 rx queue drained", q_exp[1].size(), 0);
    finish_run();
  end
endmodule